// File: doc/BRIEF.md
# Pixel Output Formatter

The formatter takes processed video samples (12-bit luma and chroma words, or 8-bit red, green and blue words) and places them on a 24-pin output bus. An 8-bit format code chooses the pin map. The maps cover single-rate 4:2:2 packing at 8, 12, 16 and 24 pins, single-rate 4:4:4 RGB, and two double-rate maps. In the double-rate maps, one value belongs to the rising half of the output clock and another to the falling half. The block drives two registered words, `pix_rise` and `pix_fall`, for the pad-level DDR cell to merge. It also drives a per-pin enable vector, so that pins a map leaves unused can float.

The format code is only adopted on a `frame_start` strobe, so one frame never mixes two maps. An unknown code floats every pin and sets a sticky error flag. In the double-rate RGB map, two consecutive valid samples form a pixel pair. The first sample is held, and both halves reach the outputs in the same cycle. In the narrow 4:2:2 maps (8 and 12 pins), the upstream stage serialises the components onto `y_in`.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `frame_start`, `pix_oe`, `pix_rise`, `pix_fall` and `fmt_err` are all zero.
- R2: Code 0x00 (8-pin single rate) places `y_in[11:4]` on pins 15..8 and enables only pins 15..8.
- R3: Code 0x0A (12-pin single rate) places `y_in[11:4]` on pins 15..8 and `y_in[3:0]` on pins 23..20, and enables only those 12 pins.
- R4: Code 0x80 (16-pin 4:2:2) places `y_in[11:4]` on pins 15..8 and `c_in[11:4]` on pins 7..0, and enables pins 15..0.
- R5: Code 0x8A (24-pin 4:2:2) adds `y_in[3:0]` on pins 23..20 and `c_in[3:0]` on pins 19..16 to the R4 map, and enables all 24 pins.
- R6: Code 0x40 (single-rate RGB) places red on pins 23..16, green on 15..8 and blue on 7..0, and enables all pins.
- R7: Code 0x20 (8-pin double rate) places `c_in[11:4]` in the rising word and `y_in[11:4]` in the falling word, both on pins 15..8, and enables only pins 15..8.
- R8: Code 0x60 (double-rate RGB) uses the R6 pin map. The even sample of a pair goes in the rising word and the odd sample in the falling word. The outputs change only on the odd sample's cycle, and both words load together.
- R9: In every single-rate map, `pix_fall` equals `pix_rise`.
- R10: A `frame_start` with any code other than the seven above clears `pix_oe` and sets `fmt_err`. `fmt_err` stays set until reset.
- R11: A change on `fmt_code` has no effect on the map or on `pix_oe` until the next `frame_start`. A `frame_start` sample is already formatted under the new code.
- R12: Outputs update one clock after a valid sample. They hold while no sample is valid. A `frame_start` cycle that loads no data clears both words, so disabled pins always carry zero.
- R13: A `frame_start` restarts the double-rate RGB pair, so the sample in that cycle is always the even one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_code | input | 8 | Requested pin-map code, adopted on `frame_start` |
| frame_start | input | 1 | Frame boundary strobe |
| sample_valid | input | 1 | The component inputs carry a sample this cycle |
| y_in | input | 12 | Luma word, or serialised components in the narrow maps |
| c_in | input | 12 | Alternating Cb/Cr word |
| r_in | input | 8 | Red component |
| g_in | input | 8 | Green component |
| b_in | input | 8 | Blue component |
| pix_rise | output | 24 | Pin data for the rising half (the only half in single-rate maps) |
| pix_fall | output | 24 | Pin data for the falling half |
| pix_oe | output | 24 | Per-pin output enable; 0 means high impedance |
| fmt_err | output | 1 | Sticky unsupported-format flag |

## Verification
The hardest case to reach is a double-rate RGB pair cut short by a frame boundary. The stimulus first sends a lone even sample, then raises `frame_start` together with a new sample. The sample in the boundary cycle must become the new even half and must not pair with the stale one. Format changes between boundaries are also forced by moving `fmt_code` while samples keep flowing. The bench then checks that the old map and enables persist. Next it issues a boundary without a sample and checks that narrower maps start from cleared words.

// File: rtl/pix_out_pkg.sv
`timescale 1ns/1ps
// Shared widths, format codes and mode type for the pixel output formatter.
// Assumes 12-bit component words and 8-bit RGB words on a 24-pin bus.
package pix_out_pkg;
    localparam int FMT_W  = 8;
    localparam int COMP_W = 12;
    localparam int RGB_W  = 8;
    localparam int BUS_W  = 3 * RGB_W;
    localparam int BYTE_W = RGB_W;
    localparam int NIB_W  = COMP_W - BYTE_W;

    localparam logic [FMT_W-1:0] CODE_SDR8   = 8'h00;
    localparam logic [FMT_W-1:0] CODE_SDR12  = 8'h0A;
    localparam logic [FMT_W-1:0] CODE_SDR16  = 8'h80;
    localparam logic [FMT_W-1:0] CODE_SDR24  = 8'h8A;
    localparam logic [FMT_W-1:0] CODE_RGB    = 8'h40;
    localparam logic [FMT_W-1:0] CODE_DDR8   = 8'h20;
    localparam logic [FMT_W-1:0] CODE_DDRRGB = 8'h60;

    typedef enum logic [2:0] {
        M_OFF, M_SDR8, M_SDR12, M_SDR16, M_SDR24, M_RGB, M_DDR8, M_DDRRGB
    } mode_e;
endpackage

// File: rtl/pix_out_decode.sv
`timescale 1ns/1ps
// Turns a format code into a mode and a per-pin enable mask.
// Purely combinational; an unknown code yields M_OFF, no enables, known=0.
module pix_out_decode
    import pix_out_pkg::*;
(
    input  logic [FMT_W-1:0] code,
    output mode_e            mode,
    output logic [BUS_W-1:0] oe_mask,
    output logic             known
);
    localparam logic [BUS_W-1:0] MID_BYTE = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
    localparam logic [BUS_W-1:0] TOP_NIB  = {{NIB_W{1'b1}}, {(BUS_W-NIB_W){1'b0}}};
    localparam logic [BUS_W-1:0] LOW_TWO  = {{BYTE_W{1'b0}}, {(2*BYTE_W){1'b1}}};
    localparam logic [BUS_W-1:0] ALL_PINS = {BUS_W{1'b1}};

    // Code lookup into mode and enable mask.
    always_comb begin
        known   = 1'b1;
        mode    = M_OFF;
        oe_mask = '0;
        case (code)
            CODE_SDR8:   begin mode = M_SDR8;   oe_mask = MID_BYTE;           end
            CODE_SDR12:  begin mode = M_SDR12;  oe_mask = MID_BYTE | TOP_NIB; end
            CODE_SDR16:  begin mode = M_SDR16;  oe_mask = LOW_TWO;            end
            CODE_SDR24:  begin mode = M_SDR24;  oe_mask = ALL_PINS;           end
            CODE_RGB:    begin mode = M_RGB;    oe_mask = ALL_PINS;           end
            CODE_DDR8:   begin mode = M_DDR8;   oe_mask = MID_BYTE;           end
            CODE_DDRRGB: begin mode = M_DDRRGB; oe_mask = ALL_PINS;           end
            default:     known = 1'b0;
        endcase
    end
endmodule

// File: rtl/pix_out_pair.sv
`timescale 1ns/1ps
// Tracks the even/odd phase of double-rate RGB pixel pairs and holds the even
// pixel until its odd partner arrives. Assumes pair_mode reflects the mode in
// force this cycle (including one adopted by restart in the same cycle).
module pix_out_pair
    import pix_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             valid,
    input  logic             pair_mode,
    input  logic [RGB_W-1:0] r_cur,
    input  logic [RGB_W-1:0] g_cur,
    input  logic [RGB_W-1:0] b_cur,
    output logic [RGB_W-1:0] r_even,
    output logic [RGB_W-1:0] g_even,
    output logic [RGB_W-1:0] b_even,
    output logic             odd_now
);
    logic want_odd;

    // The current sample completes a pair only mid-frame with an even pixel held.
    assign odd_now = valid & pair_mode & want_odd & ~restart;

    // Phase flips per pair-mode sample; a frame boundary restarts on even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_odd <= 1'b0;
        end else if (restart) begin
            want_odd <= valid & pair_mode;
        end else if (valid & pair_mode) begin
            want_odd <= ~want_odd;
        end
    end

    // Capture the even pixel of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_even <= '0;
            g_even <= '0;
            b_even <= '0;
        end else if (valid & pair_mode & ~odd_now) begin
            r_even <= r_cur;
            g_even <= g_cur;
            b_even <= b_cur;
        end
    end
endmodule

// File: rtl/pix_out_lanes.sv
`timescale 1ns/1ps
// Combinational pin map: places component fields on the rising and falling
// words for the given mode. Pins a mode leaves unused carry zero.
module pix_out_lanes
    import pix_out_pkg::*;
(
    input  mode_e             mode,
    input  logic [COMP_W-1:0] y_w,
    input  logic [COMP_W-1:0] c_w,
    input  logic [RGB_W-1:0]  r_w,
    input  logic [RGB_W-1:0]  g_w,
    input  logic [RGB_W-1:0]  b_w,
    input  logic [RGB_W-1:0]  r_e,
    input  logic [RGB_W-1:0]  g_e,
    input  logic [RGB_W-1:0]  b_e,
    output logic [BUS_W-1:0]  rise_w,
    output logic [BUS_W-1:0]  fall_w
);
    localparam int LANE_LO  = 0;
    localparam int LANE_MID = BYTE_W;
    localparam int LANE_HI  = 2 * BYTE_W;

    logic [BYTE_W-1:0] y_hi, c_hi;
    logic [NIB_W-1:0]  y_lo, c_lo;

    assign y_hi = y_w[COMP_W-1 -: BYTE_W];
    assign c_hi = c_w[COMP_W-1 -: BYTE_W];
    assign y_lo = y_w[NIB_W-1:0];
    assign c_lo = c_w[NIB_W-1:0];

    // Field placement per mode; single-rate modes mirror rise into fall.
    always_comb begin
        rise_w = '0;
        fall_w = '0;
        case (mode)
            M_SDR8: rise_w[LANE_MID +: BYTE_W] = y_hi;
            M_SDR12: begin
                rise_w[LANE_MID +: BYTE_W] = y_hi;
                rise_w[BUS_W-1 -: NIB_W]   = y_lo;
            end
            M_SDR16: begin
                rise_w[LANE_MID +: BYTE_W] = y_hi;
                rise_w[LANE_LO  +: BYTE_W] = c_hi;
            end
            M_SDR24: begin
                rise_w[LANE_MID +: BYTE_W] = y_hi;
                rise_w[LANE_LO  +: BYTE_W] = c_hi;
                rise_w[BUS_W-1 -: NIB_W]   = y_lo;
                rise_w[LANE_HI  +: NIB_W]  = c_lo;
            end
            M_RGB: rise_w = {r_w, g_w, b_w};
            M_DDR8: begin
                rise_w[LANE_MID +: BYTE_W] = c_hi;
                fall_w[LANE_MID +: BYTE_W] = y_hi;
            end
            M_DDRRGB: begin
                rise_w = {r_e, g_e, b_e};
                fall_w = {r_w, g_w, b_w};
            end
            default: rise_w = '0;
        endcase
        if (mode != M_DDR8 && mode != M_DDRRGB) begin
            fall_w = rise_w;
        end
    end
endmodule

// File: rtl/pix_out_fmt.sv
`timescale 1ns/1ps
// Pixel output formatter top. Adopts the format code at frame boundaries,
// registers rising/falling pin words and the per-pin enables, and flags
// unsupported codes. Assumes a pad-level DDR cell merges pix_rise/pix_fall.
module pix_out_fmt
    import pix_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FMT_W-1:0]  fmt_code,
    input  logic              frame_start,
    input  logic              sample_valid,
    input  logic [COMP_W-1:0] y_in,
    input  logic [COMP_W-1:0] c_in,
    input  logic [RGB_W-1:0]  r_in,
    input  logic [RGB_W-1:0]  g_in,
    input  logic [RGB_W-1:0]  b_in,
    output logic [BUS_W-1:0]  pix_rise,
    output logic [BUS_W-1:0]  pix_fall,
    output logic [BUS_W-1:0]  pix_oe,
    output logic              fmt_err
);
    mode_e             dec_mode, active_mode, eff_mode;
    logic [BUS_W-1:0]  dec_oe, map_rise, map_fall;
    logic              dec_known, odd_now, load;
    logic [RGB_W-1:0]  r_even, g_even, b_even;

    pix_out_decode u_dec (
        .code    (fmt_code),
        .mode    (dec_mode),
        .oe_mask (dec_oe),
        .known   (dec_known)
    );

    // Mode in force this cycle: a boundary applies the new code at once.
    assign eff_mode = frame_start ? dec_mode : active_mode;

    pix_out_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (frame_start),
        .valid     (sample_valid),
        .pair_mode (eff_mode == M_DDRRGB),
        .r_cur     (r_in),
        .g_cur     (g_in),
        .b_cur     (b_in),
        .r_even    (r_even),
        .g_even    (g_even),
        .b_even    (b_even),
        .odd_now   (odd_now)
    );

    pix_out_lanes u_lanes (
        .mode   (eff_mode),
        .y_w    (y_in),
        .c_w    (c_in),
        .r_w    (r_in),
        .g_w    (g_in),
        .b_w    (b_in),
        .r_e    (r_even),
        .g_e    (g_even),
        .b_e    (b_even),
        .rise_w (map_rise),
        .fall_w (map_fall)
    );

    // Pair mode loads only on the odd sample; every other mode on each sample.
    assign load = sample_valid & ((eff_mode != M_DDRRGB) | odd_now);

    // Frame-boundary state: active mode, pin enables and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mode <= M_OFF;
            pix_oe      <= '0;
            fmt_err     <= 1'b0;
        end else if (frame_start) begin
            active_mode <= dec_mode;
            pix_oe      <= dec_oe;
            if (!dec_known) begin
                fmt_err <= 1'b1;
            end
        end
    end

    // Pin data words: load on samples, clear on a boundary with no load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rise <= '0;
            pix_fall <= '0;
        end else if (load) begin
            pix_rise <= map_rise;
            pix_fall <= map_fall;
        end else if (frame_start) begin
            pix_rise <= '0;
            pix_fall <= '0;
        end
    end
endmodule

// File: rtl/pix_out_fmt_chk.sv
`timescale 1ns/1ps
// Property checker for pix_out_fmt, attached by bind. Observes ports and the
// active mode register; drives nothing.
module pix_out_fmt_chk
    import pix_out_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [FMT_W-1:0] fmt_code,
    input logic             frame_start,
    input logic             sample_valid,
    input logic [BUS_W-1:0] pix_rise,
    input logic [BUS_W-1:0] pix_fall,
    input logic [BUS_W-1:0] pix_oe,
    input logic             fmt_err,
    input mode_e            active_mode
);
    logic code_ok;
    assign code_ok = (fmt_code == 8'h00) || (fmt_code == 8'h0A) || (fmt_code == 8'h80) ||
                     (fmt_code == 8'h8A) || (fmt_code == 8'h40) || (fmt_code == 8'h20) ||
                     (fmt_code == 8'h60);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !code_ok) |=> (fmt_err && pix_oe == '0));

    assert_oe_frame_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(pix_oe));

    assert_dark_pins_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_rise & ~pix_oe) == '0) && ((pix_fall & ~pix_oe) == '0));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !frame_start) |=> ($stable(pix_rise) && $stable(pix_fall)));

    assert_sdr_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode inside {M_SDR8, M_SDR12, M_SDR16, M_SDR24, M_RGB}) |-> (pix_fall == pix_rise));
endmodule

bind pix_out_fmt pix_out_fmt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_code     (fmt_code),
    .frame_start  (frame_start),
    .sample_valid (sample_valid),
    .pix_rise     (pix_rise),
    .pix_fall     (pix_fall),
    .pix_oe       (pix_oe),
    .fmt_err      (fmt_err),
    .active_mode  (active_mode)
);

// File: tb/pix_out_fmt_test.sv
`timescale 1ns/1ps
module pix_out_fmt_test;
    localparam int CLK_NS = 4;
    localparam int WD_CYCLES = 20000;
    localparam int NVEC = 12;

    // {fmt, y, c, r, g, b, exp_rise, exp_fall, exp_oe}
    localparam logic [127:0] TBL [NVEC] = '{
        {8'h00, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'h00AB00, 24'h00AB00, 24'h00FF00},
        {8'h0A, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'hC0AB00, 24'hC0AB00, 24'hF0FF00},
        {8'h80, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'h00AB5D, 24'h00AB5D, 24'h00FFFF},
        {8'h8A, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'hC3AB5D, 24'hC3AB5D, 24'hFFFFFF},
        {8'h40, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'h9A3CE5, 24'h9A3CE5, 24'hFFFFFF},
        {8'h20, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5, 24'h005D00, 24'h00AB00, 24'h00FF00},
        {8'h00, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h001200, 24'h001200, 24'h00FF00},
        {8'h0A, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h301200, 24'h301200, 24'hF0FF00},
        {8'h80, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h0012FE, 24'h0012FE, 24'h00FFFF},
        {8'h8A, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h3D12FE, 24'h3D12FE, 24'hFFFFFF},
        {8'h40, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h0FFF00, 24'h0FFF00, 24'hFFFFFF},
        {8'h20, 12'h123, 12'hFED, 8'h0F, 8'hFF, 8'h00, 24'h00FE00, 24'h001200, 24'h00FF00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fmt_code = '0;
    logic        frame_start = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] y_in = '0, c_in = '0;
    logic [7:0]  r_in = '0, g_in = '0, b_in = '0;
    logic [23:0] pix_rise, pix_fall, pix_oe;
    logic        fmt_err;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pix_out_fmt uut (
        .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .frame_start(frame_start),
        .sample_valid(sample_valid), .y_in(y_in), .c_in(c_in), .r_in(r_in),
        .g_in(g_in), .b_in(b_in), .pix_rise(pix_rise), .pix_fall(pix_fall),
        .pix_oe(pix_oe), .fmt_err(fmt_err)
    );

    task automatic check(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock with the given strobes and sample; outputs are readable on return.
    task automatic step(input logic fs, input logic v, input logic [7:0] f,
                        input logic [11:0] y, input logic [11:0] c,
                        input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        frame_start = fs; sample_valid = v; fmt_code = f;
        y_in = y; c_in = c; r_in = r; g_in = g; b_in = b;
        @(negedge clk);
        frame_start = 1'b0; sample_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] f);
        case (f)
            8'h00: return "R2";
            8'h0A: return "R3";
            8'h80: return "R4";
            8'h8A: return "R5";
            8'h40: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(WD_CYCLES * CLK_NS);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "oe in reset", pix_oe, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "oe", pix_oe, 24'h0);
        check("R1", "rise", pix_rise, 24'h0);
        check("R1", "err", {23'h0, fmt_err}, 24'h0);

        // Table walk: each entry is a frame boundary carrying one sample.
        for (int i = 0; i < NVEC; i++) begin
            logic [127:0] e;
            e = TBL[i];
            step(1'b1, 1'b1, e[127:120], e[119:108], e[107:96], e[95:88], e[87:80], e[79:72]);
            check(tag_of(e[127:120]), "rise", pix_rise, e[71:48]);
            check(e[127:120] == 8'h20 ? "R7" : "R9", "fall", pix_fall, e[47:24]);
            check(tag_of(e[127:120]), "oe", pix_oe, e[23:0]);
        end
        check("R10", "err clear after good codes", {23'h0, fmt_err}, 24'h0);

        // R11: code change mid-frame keeps the RGB map and enables.
        step(1'b1, 1'b1, 8'h40, 12'h000, 12'h000, 8'h11, 8'h22, 8'h33);
        step(1'b0, 1'b1, 8'h80, 12'hABC, 12'h5D3, 8'h44, 8'h55, 8'h66);
        check("R11", "rise kept RGB map", pix_rise, 24'h445566);
        check("R11", "oe unchanged", pix_oe, 24'hFFFFFF);
        // R12: idle cycles hold the words.
        step(1'b0, 1'b0, 8'h80, 12'hFFF, 12'hFFF, 8'h77, 8'h77, 8'h77);
        check("R12", "hold while idle", pix_rise, 24'h445566);
        // R12/R11: boundary without a sample clears data and applies the new code.
        step(1'b1, 1'b0, 8'h00, 12'hFFF, 12'hFFF, 8'h77, 8'h77, 8'h77);
        check("R12", "cleared at empty boundary", pix_rise, 24'h000000);
        check("R11", "oe follows boundary", pix_oe, 24'h00FF00);

        // R8: double-rate RGB pairing.
        step(1'b1, 1'b1, 8'h60, 12'h000, 12'h000, 8'hA1, 8'hB2, 8'hC3);
        check("R8", "even sample loads nothing", pix_rise, 24'h000000);
        check("R8", "oe all pins", pix_oe, 24'hFFFFFF);
        step(1'b0, 1'b1, 8'h60, 12'h000, 12'h000, 8'h45, 8'h67, 8'h89);
        check("R8", "rise even pixel", pix_rise, 24'hA1B2C3);
        check("R8", "fall odd pixel", pix_fall, 24'h456789);
        step(1'b0, 1'b1, 8'h60, 12'h000, 12'h000, 8'h01, 8'h02, 8'h03);
        check("R8", "rise held until odd", pix_rise, 24'hA1B2C3);
        check("R8", "fall held until odd", pix_fall, 24'h456789);
        // R13: boundary with a pending even sample restarts the pair.
        step(1'b1, 1'b1, 8'h60, 12'h000, 12'h000, 8'hD1, 8'hD2, 8'hD3);
        step(1'b0, 1'b1, 8'h60, 12'h000, 12'h000, 8'hE1, 8'hE2, 8'hE3);
        check("R13", "rise from boundary sample", pix_rise, 24'hD1D2D3);
        check("R13", "fall", pix_fall, 24'hE1E2E3);

        // R10: unknown code floats pins and sets sticky error.
        step(1'b1, 1'b1, 8'h13, 12'hABC, 12'h5D3, 8'h9A, 8'h3C, 8'hE5);
        check("R10", "oe off", pix_oe, 24'h000000);
        check("R10", "data zero", pix_rise, 24'h000000);
        check("R10", "err set", {23'h0, fmt_err}, 24'h1);
        step(1'b1, 1'b1, 8'h40, 12'h000, 12'h000, 8'h9A, 8'h3C, 8'hE5);
        check("R10", "err sticky", {23'h0, fmt_err}, 24'h1);
        check("R6", "recovered map", pix_rise, 24'h9A3CE5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule